// File: doc/BRIEF.md
# Indexed CSR memory read port

This block lets a register bus read back the contents of three internal 64-bit memories without giving each memory its own address range. Software sets a single index register. That register holds a 16-bit read pointer and a 16-bit stride. Each CSR read that targets one of the memory addresses returns the entry at the current pointer. The stride is then added to the pointer, so a run of reads walks through a memory at any step size, including backwards.

The memories are filled from the datapath side. Each memory has its own write port. The block keeps a per-entry flag that records whether the entry has been written since reset. Every memory read reports that flag on a sideband output, so a read of stale or never-written storage can be seen.

The CSR bus carries at most one operation per cycle. `csr_rd` and `csr_wr` are never high together.

Top module: `idxmem_csr_port`

## Requirements
- R1: After reset the pointer and the stride are zero, `csr_rvalid` is low, and every entry is marked as not written.
- R2: A write to CSR address 0 loads the pointer from `csr_wdata[15:0]` and the stride from `csr_wdata[31:16]`. A read of address 0 returns the stride in bits [31:16], the pointer in bits [15:0], and zero in bits [63:32].
- R3: CSR addresses 1, 2 and 3 read memory 0 (32 entries), memory 1 (256 entries) and memory 2 (256 entries). Each returns the entry at the pointer.
- R4: After every read of address 1, 2 or 3, the pointer becomes pointer plus stride, modulo 2^16.
- R5: A read of address 0, or of any address from 4 to 15, leaves the pointer unchanged. Reads of addresses 4 to 15 return zero.
- R6: A memory takes the pointer's low bits as its entry address: 5 bits for memory 0 and 8 bits for memories 1 and 2.
- R7: `csr_unwritten` is high, together with `csr_rvalid`, when a memory read hits an entry that has not been written since reset. It is low for written entries and for reads that are not memory reads.
- R8: `csr_rvalid` is high in exactly the cycle after each read request. The read data is valid in that same cycle.
- R9: With pointer 0 and stride 1, back-to-back reads, one per cycle, return a whole memory in entry order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_rd | input | 1 | CSR read request |
| csr_wr | input | 1 | CSR write request |
| csr_addr | input | 4 | CSR address |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | CSR read data, valid with `csr_rvalid` |
| csr_rvalid | output | 1 | Read data strobe |
| csr_unwritten | output | 1 | The read hit an entry that has not been written |
| m0_we | input | 1 | Memory 0 write enable |
| m0_waddr | input | 5 | Memory 0 write address |
| m0_wdata | input | 64 | Memory 0 write data |
| m1_we | input | 1 | Memory 1 write enable |
| m1_waddr | input | 8 | Memory 1 write address |
| m1_wdata | input | 64 | Memory 1 write data |
| m2_we | input | 1 | Memory 2 write enable |
| m2_waddr | input | 8 | Memory 2 write address |
| m2_wdata | input | 64 | Memory 2 write data |

## Verification
The memories are partly filled with a pattern that encodes both the memory number and the entry, and are then read through the pointer in several ways:
- A unit stride across all of memory 0 shows the streaming order and the selection of each memory.
- A stride of 3 from pointer 0x0125 shows that each memory uses only the pointer's low bits.
- A start at 0xFFFE shows the 16-bit wrap.
- A stride of 0xFFFF shows that reads can walk backwards.
- A stride of 0 shows that repeated reads hit the same entry.
- Runs that cross the boundary between filled and empty entries show the unwritten flag switching in both directions.

Reads of address 0 and of a non-memory address between runs confirm that only memory reads move the pointer.

// File: rtl/idxmem_pkg.sv
package idxmem_pkg;
   localparam int CSR_AW  = 4;
   localparam int IDX_W   = 16;
   localparam int NUM_MEM = 3;

   localparam logic [CSR_AW-1:0] ADDR_IDX      = 4'd0;
   localparam logic [CSR_AW-1:0] ADDR_MEM_BASE = 4'd1;

   function automatic logic addr_is_mem(input logic [CSR_AW-1:0] a);
      return (a >= ADDR_MEM_BASE) && (a < ADDR_MEM_BASE + CSR_AW'(NUM_MEM));
   endfunction
endpackage

// File: rtl/idxmem_index.sv
module idxmem_index
   import idxmem_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [2*IDX_W-1:0] load_val,
   input  logic               step,
   output logic [IDX_W-1:0]   ptr,
   output logic [IDX_W-1:0]   stride
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         stride <= '0;
      end else if (load) begin
         ptr    <= load_val[IDX_W-1:0];
         stride <= load_val[2*IDX_W-1:IDX_W];
      end else if (step) begin
         ptr <= ptr + stride;
      end
   end
endmodule

// File: rtl/idxmem_bank.sv
module idxmem_bank #(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 64,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_seen
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("idxmem_bank: DEPTH must be a power of two of at least 2");
   end

   logic [DATA_W-1:0] store [DEPTH];
   logic [DEPTH-1:0]  seen;

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      if (rd_en) rdata <= store[raddr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen    <= '0;
         rd_seen <= 1'b0;
      end else begin
         if (we) seen[waddr] <= 1'b1;
         if (rd_en) rd_seen <= seen[raddr];
      end
   end
endmodule

// File: rtl/idxmem_csr_port.sv
module idxmem_csr_port
   import idxmem_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int DEPTH0 = 32,
   parameter int DEPTH1 = 256,
   parameter int DEPTH2 = 256
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      csr_rd,
   input  logic                      csr_wr,
   input  logic [CSR_AW-1:0]         csr_addr,
   input  logic [DATA_W-1:0]         csr_wdata,
   output logic [DATA_W-1:0]         csr_rdata,
   output logic                      csr_rvalid,
   output logic                      csr_unwritten,
   input  logic                      m0_we,
   input  logic [$clog2(DEPTH0)-1:0] m0_waddr,
   input  logic [DATA_W-1:0]         m0_wdata,
   input  logic                      m1_we,
   input  logic [$clog2(DEPTH1)-1:0] m1_waddr,
   input  logic [DATA_W-1:0]         m1_wdata,
   input  logic                      m2_we,
   input  logic [$clog2(DEPTH2)-1:0] m2_waddr,
   input  logic [DATA_W-1:0]         m2_wdata
);
   localparam int DEPTHS [NUM_MEM] = '{DEPTH0, DEPTH1, DEPTH2};
   localparam int MAX_AW = 8 > $clog2(DEPTH0) ? 8 : $clog2(DEPTH0);

   if (DATA_W < 2*IDX_W) begin : g_bad_width
      $error("idxmem_csr_port: DATA_W must hold pointer and stride");
   end
   if (DEPTH1 > 256 || DEPTH2 > 256 || DEPTH0 > 256) begin : g_bad_depth
      $error("idxmem_csr_port: depths above 256 are not supported");
   end

   logic [IDX_W-1:0] idx_q, inc_q;
   logic             ptr_load, ptr_step;

   assign ptr_load = csr_wr && (csr_addr == ADDR_IDX);
   assign ptr_step = csr_rd && addr_is_mem(csr_addr);

   idxmem_index u_index (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (csr_wdata[2*IDX_W-1:0]),
      .step     (ptr_step),
      .ptr      (idx_q),
      .stride   (inc_q)
   );

   logic                            unused_wdata;
   assign unused_wdata = ^csr_wdata[DATA_W-1:2*IDX_W];

   logic [NUM_MEM-1:0]              bank_we;
   logic [NUM_MEM-1:0][MAX_AW-1:0]  bank_waddr;
   logic [NUM_MEM-1:0][DATA_W-1:0]  bank_wdata;
   logic [NUM_MEM-1:0][DATA_W-1:0]  bank_rdata;
   logic [NUM_MEM-1:0]              bank_seen;
   logic [NUM_MEM-1:0]              bank_hit;
   logic [NUM_MEM-1:0]              sel_q;

   assign bank_we    = {m2_we, m1_we, m0_we};
   assign bank_waddr = {MAX_AW'(m2_waddr), MAX_AW'(m1_waddr), MAX_AW'(m0_waddr)};
   assign bank_wdata = {m2_wdata, m1_wdata, m0_wdata};

   for (genvar k = 0; k < NUM_MEM; k++) begin : g_bank
      localparam int AWK = $clog2(DEPTHS[k]);
      assign bank_hit[k] = csr_rd && (csr_addr == ADDR_MEM_BASE + CSR_AW'(k));
      idxmem_bank #(.DEPTH(DEPTHS[k]), .DATA_W(DATA_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .we      (bank_we[k]),
         .waddr   (bank_waddr[k][AWK-1:0]),
         .wdata   (bank_wdata[k]),
         .rd_en   (bank_hit[k]),
         .raddr   (idx_q[AWK-1:0]),
         .rdata   (bank_rdata[k]),
         .rd_seen (bank_seen[k])
      );
   end

   logic                 ctl_sel_q, rvalid_q;
   logic [2*IDX_W-1:0]   ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= '0;
         ctl_sel_q <= 1'b0;
         rvalid_q  <= 1'b0;
         ctl_q     <= '0;
      end else begin
         sel_q     <= bank_hit;
         ctl_sel_q <= csr_rd && (csr_addr == ADDR_IDX);
         rvalid_q  <= csr_rd;
         if (csr_rd && csr_addr == ADDR_IDX) ctl_q <= {inc_q, idx_q};
      end
   end

   always_comb begin
      csr_rdata     = ctl_sel_q ? DATA_W'(ctl_q) : '0;
      csr_unwritten = 1'b0;
      for (int k = 0; k < NUM_MEM; k++) begin
         if (sel_q[k]) begin
            csr_rdata     = csr_rdata | bank_rdata[k];
            csr_unwritten = csr_unwritten | ~bank_seen[k];
         end
      end
   end

   assign csr_rvalid = rvalid_q;
endmodule

// File: rtl/idxmem_csr_port_chk.sv
module idxmem_csr_port_chk
   import idxmem_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csr_rd,
   input logic              csr_wr,
   input logic [CSR_AW-1:0] csr_addr,
   input logic [DATA_W-1:0] csr_wdata,
   input logic [DATA_W-1:0] csr_rdata,
   input logic              csr_rvalid,
   input logic              csr_unwritten,
   input logic [IDX_W-1:0]  idx,
   input logic [IDX_W-1:0]  inc
);
   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_wr && csr_addr == ADDR_IDX) |=>
         (idx == $past(csr_wdata[IDX_W-1:0]) && inc == $past(csr_wdata[2*IDX_W-1:IDX_W])));

   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd && addr_is_mem(csr_addr)) |=> (idx == IDX_W'($past(idx) + $past(inc))));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd && !addr_is_mem(csr_addr)) |=> $stable(idx));

   assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rd && csr_addr >= ADDR_MEM_BASE + CSR_AW'(NUM_MEM)) |=> (csr_rdata == '0));

   assert_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      csr_unwritten |-> csr_rvalid);

   assert_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rd |=> csr_rvalid);

   assert_novalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !csr_rd |=> !csr_rvalid);
endmodule

bind idxmem_csr_port idxmem_csr_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .csr_rd        (csr_rd),
   .csr_wr        (csr_wr),
   .csr_addr      (csr_addr),
   .csr_wdata     (csr_wdata),
   .csr_rdata     (csr_rdata),
   .csr_rvalid    (csr_rvalid),
   .csr_unwritten (csr_unwritten),
   .idx           (idx_q),
   .inc           (inc_q)
);

// File: tb/idxmem_csr_port_bench.sv
`timescale 1ns/1ps
module idxmem_csr_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_rd = 1'b0, csr_wr = 1'b0;
   logic [3:0]  csr_addr = '0;
   logic [63:0] csr_wdata = '0;
   logic [63:0] csr_rdata;
   logic        csr_rvalid, csr_unwritten;
   logic        m0_we = 1'b0, m1_we = 1'b0, m2_we = 1'b0;
   logic [4:0]  m0_waddr = '0;
   logic [7:0]  m1_waddr = '0, m2_waddr = '0;
   logic [63:0] m0_wdata = '0, m1_wdata = '0, m2_wdata = '0;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   idxmem_csr_port u_idxmem_csr_port (.*);

   // Vector: {addr[3:0], start[15:0], stride[15:0], count[7:0]}
   localparam logic [43:0] VEC [6] = '{
      {4'd1, 16'h0000, 16'h0001, 8'd32},  // R9 full stream of memory 0
      {4'd2, 16'h0125, 16'h0003, 8'd6},   // R6 low bits, stride 3
      {4'd3, 16'hFFFE, 16'h0001, 8'd4},   // R4 wrap, R7 unwritten to written
      {4'd1, 16'h001F, 16'hFFFF, 8'd4},   // R4 backwards walk
      {4'd2, 16'h00C6, 16'h0001, 8'd4},   // R7 written to unwritten
      {4'd3, 16'h0005, 16'h0000, 8'd3}    // R3 zero stride
   };

   function automatic logic [63:0] pat(input int m, input int a);
      return {4'hA, 4'(m), 8'(a), 16'h5A5A ^ 16'(a * 37), 32'hDEAD0000 | 32'(m * 256 + a)};
   endfunction

   function automatic bit filled(input int m, input int a);
      return (m == 0) ? (a < 32) : (m == 1) ? (a < 200) : (a < 128);
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic csr_write(input logic [63:0] d);
      @(negedge clk);
      csr_wr = 1'b1; csr_addr = 4'd0; csr_wdata = d;
      @(negedge clk);
      csr_wr = 1'b0;
   endtask

   task automatic csr_read(input logic [3:0] a, output logic [63:0] d, output logic unw, output logic v);
      @(negedge clk);
      csr_rd = 1'b1; csr_addr = a;
      @(negedge clk);
      csr_rd = 1'b0;
      d = csr_rdata; unw = csr_unwritten; v = csr_rvalid;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      logic        u, v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check(csr_rvalid == 1'b0, "R1 rvalid low", 64'(csr_rvalid), 64'd0);
      csr_read(4'd0, d, u, v);
      check(d == 64'd0, "R1 pointer and stride zero", d, 64'd0);
      csr_read(4'd1, d, u, v);
      check(u == 1'b1 && v == 1'b1, "R1 R7 entry unwritten after reset", 64'(u), 64'd1);
      @(negedge clk);
      check(csr_rvalid == 1'b0, "R8 rvalid single cycle", 64'(csr_rvalid), 64'd0);

      // fill
      for (int a = 0; a < 256; a++) begin
         @(negedge clk);
         m0_we = filled(0, a); m0_waddr = 5'(a); m0_wdata = pat(0, a);
         m1_we = filled(1, a); m1_waddr = 8'(a); m1_wdata = pat(1, a);
         m2_we = filled(2, a); m2_waddr = 8'(a); m2_wdata = pat(2, a);
      end
      @(negedge clk);
      m0_we = 1'b0; m1_we = 1'b0; m2_we = 1'b0;

      // R2: upper bits ignored on write, read back as zero
      csr_write(64'hFFFF_FFFF_1234_ABCD);
      csr_read(4'd0, d, u, v);
      check(d == 64'h0000_0000_1234_ABCD, "R2 index register readback", d, 64'h1234ABCD);
      check(u == 1'b0, "R7 no flag on index read", 64'(u), 64'd0);

      // table walk
      for (int t = 0; t < 6; t++) begin
         logic [3:0]  va;
         logic [15:0] st, sd, p, prev;
         int          cnt, m, aw;
         {va, st, sd} = VEC[t][43:8];
         cnt = int'(VEC[t][7:0]);
         m = int'(va) - 1;
         csr_write({32'd0, sd, st});
         p = st; prev = st;
         for (int i = 0; i <= cnt; i++) begin
            @(negedge clk);
            if (i > 0) begin
               aw = (m == 0) ? int'(prev[4:0]) : int'(prev[7:0]);
               check(csr_rvalid == 1'b1, "R8 rvalid on stream", 64'(csr_rvalid), 64'd1);
               check(csr_unwritten == !filled(m, aw), "R7 unwritten flag",
                     64'(csr_unwritten), 64'(!filled(m, aw)));
               if (filled(m, aw))
                  check(csr_rdata == pat(m, aw), "R3 R6 R9 entry data", csr_rdata, pat(m, aw));
            end
            if (i < cnt) begin
               csr_rd = 1'b1; csr_addr = va;
               prev = p; p = p + sd;
            end else begin
               csr_rd = 1'b0;
            end
         end
         // R5: non-memory read returns zero and keeps pointer
         csr_read(4'd9, d, u, v);
         check(d == 64'd0 && u == 1'b0, "R5 non-memory read zero", d, 64'd0);
         csr_read(4'd0, d, u, v);
         check(d == {32'd0, sd, p}, "R4 R5 final pointer", d, {32'd0, sd, p});
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule